// File: doc/BRIEF.md
# Ramped Digital Volume Attenuator

This block scales a stereo pair of signed audio samples by a programmable linear level. A small write port carries an opcode and an 8-bit data byte. One opcode loads the stored attenuation byte. Another opcode sets or clears an enable bit. While the enable bit is clear, the block aims for unity gain. While it is set, it aims for the stored byte.

The applied level never jumps. A 9-bit level register moves one unit toward the present target on every fourth sample strobe. It can hold every value from 0 up to 256, where 256 means unity. If the target changes part way through a ramp, the level turns from its present value toward the new target. A full 255-unit sweep takes 1020 sample periods, about 23 ms at 44.1 kHz.

Each output sample is the input times the level, divided by 256. The quotient is truncated toward zero and clamped to the signed sample range. Outputs are registered on the strobe edge.

Top module: `vol_ramp_atten`

## Requirements
- R1: After reset the outputs are 0 and `smp_out_valid` is 0. The stored byte is 64 and the enable bit is 0. The level starts at 256, so the first samples pass through unchanged.
- R2: A write with `cmd_op` = 0x84 stores `cmd_data` (0 to 255) as the attenuation byte.
- R3: A write with `cmd_op` = 0x83 sets the enable bit to `cmd_data[0]`. Writes with any other opcode change neither the stored byte nor the enable bit. The stored byte has no effect while the enable bit is 0.
- R4: On a clock edge with `smp_strobe` high, both outputs are loaded and `smp_out_valid` is 1 in the following cycle. Each output is the matching input times the level held before that edge, divided by 256. The quotient is truncated toward zero and saturated to the signed DATA_W range.
- R5: A prescaler counts strobes from 0 to 3 and wraps. The level moves exactly one unit toward the target only on the strobe where the count wraps from 3 to 0.
- R6: The target is re-read on every step. A new setting that arrives mid-ramp makes the level head toward the newest target from its present value.
- R7: With the enable bit 0 the target is 256. Clearing the bit ramps the level back to unity at the same rate.
- R8: In cycles after an edge with no strobe, `smp_out_valid` is 0 and both outputs hold their previous values.
- R9: The level never leaves the range 0 to 256 and never passes its target. A level of 0 gives silent outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write strobe for the command port |
| cmd_op | input | 8 | Opcode: 0x84 loads the attenuation byte, 0x83 loads the enable bit |
| cmd_data | input | 8 | Data byte for the write |
| smp_strobe | input | 1 | One cycle per sample period |
| smp_in_l | input | DATA_W | Left input sample, signed |
| smp_in_r | input | DATA_W | Right input sample, signed |
| smp_out_l | output | DATA_W | Left scaled sample, signed |
| smp_out_r | output | DATA_W | Right scaled sample, signed |
| smp_out_valid | output | 1 | High for one cycle after each strobe |

## Verification
The level register can only be seen at the ports through the scaled samples. The bench therefore drives an input of 256 during the ramps, which makes each output equal to the level in effect. A level that steps on the wrong strobe shows up as a one-unit difference one cycle after that strobe. A prescaler phase error shows up within four strobes. A level that moves the wrong way, or a target that is decoded wrongly, grows into a mismatch on every later sample. Random stimulus covers rounding of negative products and commands that arrive in the same cycle as a strobe.

// File: rtl/vra_pkg.sv
package vra_pkg;
    localparam int OP_W  = 8;
    localparam int ATT_W = 8;
    localparam logic [OP_W-1:0] OP_SET_LEVEL  = 8'h84;
    localparam logic [OP_W-1:0] OP_SET_ENABLE = 8'h83;

    typedef struct packed {
        logic [ATT_W-1:0] atten;
        logic             enable;
    } cfg_t;
endpackage

// File: rtl/vra_cmd_regs.sv
module vra_cmd_regs
    import vra_pkg::*;
#(
    parameter int RESET_ATTEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [ATT_W-1:0] cmd_data,
    output cfg_t             cfg_o
);
    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid && cmd_op == OP_SET_LEVEL) begin
            st_d.atten = cmd_data;
        end
        if (cmd_valid && cmd_op == OP_SET_ENABLE) begin
            st_d.enable = cmd_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.atten  <= ATT_W'(RESET_ATTEN);
            st_q.enable <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q;

    // R3: only the matching opcode may touch each field
    a_r3_level_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == OP_SET_LEVEL) |=> $stable(st_q.atten));
    a_r3_enable_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == OP_SET_ENABLE) |=> $stable(st_q.enable));
endmodule

// File: rtl/vra_ramp.sv
module vra_ramp #(
    parameter int LVL_W       = 9,
    parameter int STEP_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [LVL_W-1:0] target_i,
    output logic [LVL_W-1:0] level_o
);
    localparam int CNT_W = (STEP_PERIOD > 1) ? $clog2(STEP_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_PERIOD - 1);
    localparam logic [LVL_W-1:0] UNITY    = LVL_W'(1) << (LVL_W - 1);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [CNT_W-1:0] cnt;
    } ramp_t;

    ramp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                if (st_q.lvl < target_i) begin
                    st_d.lvl = st_q.lvl + 1'b1;
                end else if (st_q.lvl > target_i) begin
                    st_d.lvl = st_q.lvl - 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= UNITY;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;

    // R5: single-unit moves, and only on a wrapping strobe
    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |->
        (st_q.lvl == $past(st_q.lvl) + 1'b1 || st_q.lvl == $past(st_q.lvl) - 1'b1));
    a_r5_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |->
        ($past(strobe_i) && $past(st_q.cnt) == CNT_LAST));
    // R6: every move heads toward the target in force at that edge
    a_r6_up_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl > $past(st_q.lvl)) |-> ($past(target_i) > $past(st_q.lvl)));
    a_r6_down_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl < $past(st_q.lvl)) |-> ($past(target_i) < $past(st_q.lvl)));
    // R9: level stays within 0..unity
    a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= UNITY);
endmodule

// File: rtl/vra_scale.sv
module vra_scale #(
    parameter int DATA_W = 16,
    parameter int LVL_W  = 9
) (
    input  logic signed [DATA_W-1:0] smp_i,
    input  logic        [LVL_W-1:0]  level_i,
    output logic signed [DATA_W-1:0] smp_o
);
    localparam int PW    = DATA_W + LVL_W + 1;
    localparam int SHIFT = LVL_W - 1;
    localparam logic signed [PW-1:0] ROUND_ADJ = PW'((1 << SHIFT) - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] a_ext, b_ext, prod, adj, quo;

    always_comb begin
        a_ext = PW'(smp_i);
        b_ext = PW'(level_i);
        prod  = a_ext * b_ext;
        adj   = prod[PW-1] ? (prod + ROUND_ADJ) : prod;
        quo   = adj >>> SHIFT;
        if (quo > MAXV) begin
            smp_o = MAXV[DATA_W-1:0];
        end else if (quo < MINV) begin
            smp_o = MINV[DATA_W-1:0];
        end else begin
            smp_o = quo[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten
    import vra_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LVL_W       = 9,
    parameter int STEP_PERIOD = 4,
    parameter int RESET_ATTEN = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [OP_W-1:0]          cmd_op,
    input  logic [ATT_W-1:0]         cmd_data,
    input  logic                     smp_strobe,
    input  logic signed [DATA_W-1:0] smp_in_l,
    input  logic signed [DATA_W-1:0] smp_in_r,
    output logic signed [DATA_W-1:0] smp_out_l,
    output logic signed [DATA_W-1:0] smp_out_r,
    output logic                     smp_out_valid
);
    localparam int NCH = 2;
    localparam logic [LVL_W-1:0] UNITY = LVL_W'(1) << (LVL_W - 1);

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] smp;
        logic                       vld;
    } out_t;

    cfg_t             cfg;
    logic [LVL_W-1:0] target, level;
    logic [NCH-1:0][DATA_W-1:0] ch_in, ch_scaled;
    out_t             st_d, st_q;

    vra_cmd_regs #(.RESET_ATTEN(RESET_ATTEN)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_data (cmd_data),
        .cfg_o    (cfg)
    );

    assign target = cfg.enable ? LVL_W'(cfg.atten) : UNITY;

    vra_ramp #(.LVL_W(LVL_W), .STEP_PERIOD(STEP_PERIOD)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(smp_strobe),
        .target_i(target),
        .level_o (level)
    );

    assign ch_in[0] = smp_in_l;
    assign ch_in[1] = smp_in_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vra_scale #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_scale (
            .smp_i  (ch_in[c]),
            .level_i(level),
            .smp_o  (ch_scaled[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_strobe;
        if (smp_strobe) begin
            st_d.smp = ch_scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_out_l     = st_q.smp[0];
    assign smp_out_r     = st_q.smp[1];
    assign smp_out_valid = st_q.vld;

    // R4: a strobe yields a valid flag on the next cycle
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_strobe |=> smp_out_valid);
    // R8: no strobe, no valid flag and no change on the outputs
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_strobe |=> (!smp_out_valid && $stable(smp_out_l) && $stable(smp_out_r)));
    // R4: the magnitude of an output never exceeds the magnitude of its input
    a_r4_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe && smp_in_l >= 0) |=> (smp_out_l >= 0 && smp_out_l <= $past(smp_in_l)));
endmodule

// File: tb/vol_ramp_atten_tb.sv
module vol_ramp_atten_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_op = '0;
    logic [7:0] cmd_data = '0;
    logic smp_strobe = 1'b0;
    logic signed [DW-1:0] smp_in_l = '0;
    logic signed [DW-1:0] smp_in_r = '0;
    logic signed [DW-1:0] smp_out_l, smp_out_r;
    logic smp_out_valid;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_att, m_en, m_lvl, m_cnt;
    int e_l, e_r, e_v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vol_ramp_atten u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .smp_strobe(smp_strobe), .smp_in_l(smp_in_l),
        .smp_in_r(smp_in_r), .smp_out_l(smp_out_l), .smp_out_r(smp_out_r),
        .smp_out_valid(smp_out_valid)
    );

    function automatic int ref_scale(int x, int lvl);
        int p, q;
        p = x * lvl;
        if (p < 0) q = -((-p) / 256);
        else       q = p / 256;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_att = 64; m_en = 0; m_lvl = 256; m_cnt = 0;
        e_l = 0; e_r = 0; e_v = 0;
    endtask

    task automatic step(bit stb, bit cv, int op, int data, int l, int r);
        int tgt;
        @(negedge clk);
        smp_strobe = stb; cmd_valid = cv;
        cmd_op = 8'(op); cmd_data = 8'(data);
        smp_in_l = DW'(l); smp_in_r = DW'(r);
        @(posedge clk);
        tgt = m_en ? m_att : 256;
        e_v = stb;
        if (stb) begin
            e_l = ref_scale(l, m_lvl);
            e_r = ref_scale(r, m_lvl);
            if (m_cnt == 3) begin
                m_cnt = 0;
                if (m_lvl < tgt) m_lvl++;
                else if (m_lvl > tgt) m_lvl--;
            end else begin
                m_cnt++;
            end
        end
        if (cv && op == 8'h84) m_att = data & 8'hff;
        if (cv && op == 8'h83) m_en = data & 1;
        #1;
        chk(stb ? cur_req : "R8", "valid", int'(smp_out_valid), e_v);
        chk(stb ? cur_req : "R8", "out_l", int'(smp_out_l), e_l);
        chk(stb ? cur_req : "R8", "out_r", int'(smp_out_r), e_r);
    endtask

    // strobe every other cycle so that hold cycles are checked as well
    task automatic strobes(int n, int l, int r);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 0, 0, l, r);
            step(1'b0, 1'b0, 0, 0, -l, -r);
        end
    endtask

    task automatic wr(int op, int data);
        step(1'b0, 1'b1, op, data, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1207));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "valid after reset", int'(smp_out_valid), 0);
        chk("R1", "out_l after reset", int'(smp_out_l), 0);
        chk("R1", "out_r after reset", int'(smp_out_r), 0);
        cur_req = "R1";
        strobes(2, 1234, -4321);
        // R4: full-scale inputs at unity
        cur_req = "R4";
        strobes(2, 32767, -32768);
        // R3: stored byte has no effect while disabled; R2 load it
        cur_req = "R2";
        wr(8'h84, 128);
        cur_req = "R3";
        strobes(8, 256, 256);
        chk("R3", "disabled stays unity", int'(smp_out_l), 256);
        // R5: enable and watch the downward ramp
        wr(8'h83, 1);
        cur_req = "R5";
        strobes(200, 256, -256);
        chk("R5", "level after 200 strobes", int'(smp_out_l), 207);
        // R6: retarget mid-ramp to a higher value, then lower
        cur_req = "R6";
        wr(8'h84, 230);
        strobes(60, 256, 256);
        wr(8'h84, 200);
        strobes(120, 256, -256);
        // R3: foreign opcodes ignored
        cur_req = "R3";
        wr(8'h85, 3);
        wr(8'h04, 0);
        wr(8'h82, 0);
        strobes(40, 256, 256);
        // R4: negative rounding toward zero
        cur_req = "R4";
        strobes(8, -1, -255);
        strobes(8, -32768, 32767);
        // R7: disable ramps back to unity
        cur_req = "R7";
        wr(8'h83, 0);
        strobes(300, 256, 256);
        chk("R7", "back at unity", int'(smp_out_l), 256);
        // R9: full sweep to zero gives silence and stays there
        cur_req = "R9";
        wr(8'h84, 0);
        wr(8'h83, 1);
        strobes(1040, 256, -30000);
        chk("R9", "silent at level 0", int'(smp_out_r), 0);
        // random mix
        cur_req = "R4";
        for (int i = 0; i < 20000; i++) begin
            bit stb, cv;
            int op, dat, l, r;
            stb = ($urandom % 3) == 0;
            cv  = ($urandom % 150) == 0;
            op  = ($urandom % 2) ? 8'h84 : (($urandom % 2) ? 8'h83 : int'($urandom % 256));
            dat = int'($urandom % 256);
            l   = int'($urandom % 65536) - 32768;
            r   = int'($urandom % 65536) - 32768;
            step(stb, cv, op, dat, l, r);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule